// File: doc/BRIEF.md
# Pipeline Bypass and Interlock Controller

This block is the purely combinational steering logic for a five-stage in-order integer pipeline in which branches are resolved in the decode stage. It looks at the register numbers and control flags held in the four staging registers and makes two decisions. The first is where each of four operands should take its value from: the register file, the result waiting in the memory stage, or the result waiting in writeback. The four operands are the two ALU inputs in execute and the two inputs of the decode-stage equality comparator. The second is whether the front of the pipeline must wait.

When waiting is needed, the controller holds the program counter and the fetch/decode register and turns the instruction entering execute into a no-op. A plain load followed by a consumer waits one cycle. A branch that needs the result of an ALU operation still in execute waits one cycle. A branch that needs a load result waits two cycles if the load is directly ahead, or one cycle if the load is already in the memory stage. A taken branch that is not waiting discards the fetched instruction. The multiplexers, register file and ALU belong to the surrounding datapath.

Top module: `fwdctl_top`

## Requirements
- R1: An execute operand selects the memory stage (code 2'b10) when the memory-stage instruction writes a register, its destination is nonzero, and that destination equals the operand's source (rs for operand A, rt for operand B).
- R2: When R1 does not apply, an execute operand selects writeback (code 2'b01) under the same three conditions applied to the writeback stage. Otherwise it selects the register file (code 2'b00).
- R3: When the execute-stage instruction reads memory and its destination equals the decode-stage rs or rt, hold_pc_o, hold_ifid_o and bubble_idex_o are all 1.
- R4: A branch in decode whose rs or rt equals the nonzero destination of a register-writing instruction in execute raises the three stall outputs.
- R5: A branch in decode whose rs or rt equals the nonzero destination of a load in the memory stage raises the three stall outputs. A load two stages ahead that is already in writeback causes no stall.
- R6: A decode comparator operand selects the memory stage (2'b10) only when the memory-stage instruction writes a nonzero matching register and is not a load. Otherwise it selects writeback (2'b01) when writeback matches under the rules of R2, and otherwise the register file (2'b00).
- R7: flush_ifid_o is 1 exactly when a branch in decode is taken and no stall is raised.
- R8: Register 0 is never bypassed. With no hazard, all selects are 2'b00 and all stall and flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | REG_W | Decode-stage first source register |
| id_rt_i | input | REG_W | Decode-stage second source register |
| id_branch_i | input | 1 | Decode-stage instruction is a compare-and-branch |
| id_taken_i | input | 1 | Decode comparator outcome: branch taken |
| ex_rs_i | input | REG_W | Execute-stage first source register |
| ex_rt_i | input | REG_W | Execute-stage second source register |
| ex_dst_i | input | REG_W | Execute-stage destination register |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction reads memory |
| mem_dst_i | input | REG_W | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction reads memory |
| wb_dst_i | input | REG_W | Writeback-stage destination register |
| wb_we_i | input | 1 | Writeback-stage instruction writes a register |
| ex_a_sel_o | output | 2 | Source select for ALU operand A |
| ex_b_sel_o | output | 2 | Source select for ALU operand B |
| id_a_sel_o | output | 2 | Source select for comparator operand A |
| id_b_sel_o | output | 2 | Source select for comparator operand B |
| hold_pc_o | output | 1 | Keep the program counter |
| hold_ifid_o | output | 1 | Keep the fetch/decode register |
| bubble_idex_o | output | 1 | Clear write enables entering execute |
| flush_ifid_o | output | 1 | Zero the fetch/decode register |

## Verification
The bench builds the block with the default REG_W of 5 but draws every register field from the range 0 to 3. This makes matches between stages, including matches on register 0, frequent enough that the priority between stages is exercised thousands of times. It also reaches the overlaps between load-use, branch-on-ALU and branch-on-load conditions. Directed sequences replay a load-then-use pair and the one- and two-cycle branch waits stage by stage.

// File: rtl/fwdctl_pkg.sv
package fwdctl_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/fwdctl_pick.sv
module fwdctl_pick
  import fwdctl_pkg::*;
#(
  parameter int unsigned REG_W      = 5,
  parameter bit          LOAD_GUARD = 1'b0  // decode side: a load in MEM has no value yet
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             mem_we_i,
  input  logic             mem_load_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             wb_we_i,
  input  logic [REG_W-1:0] wb_dst_i,
  output logic [1:0]       sel_o
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_we_i && (mem_dst_i != '0) && (mem_dst_i == src_i)
              && !(LOAD_GUARD && mem_load_i);
    wb_hit  = wb_we_i && (wb_dst_i != '0) && (wb_dst_i == src_i);
    if (mem_hit)     sel_o = SEL_MEM;
    else if (wb_hit) sel_o = SEL_WB;
    else             sel_o = SEL_RF;
  end

  always_comb begin
    a_r8_sel_legal: assert ($onehot0(sel_o));
    if (sel_o == SEL_WB)
      a_r2_wb_match: assert (wb_dst_i == src_i && wb_dst_i != '0);
    if (sel_o == SEL_MEM)
      a_r1_mem_match: assert (mem_dst_i == src_i && mem_we_i);
  end
endmodule

// File: rtl/fwdctl_hazard.sv
module fwdctl_hazard #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic             id_taken_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_load_i,
  output logic             stall_o,
  output logic             flush_o
);
  logic ex_match, mem_match, load_use, br_on_ex, br_on_mem;

  always_comb begin
    ex_match  = (ex_dst_i == id_rs_i) || (ex_dst_i == id_rt_i);
    mem_match = (mem_dst_i == id_rs_i) || (mem_dst_i == id_rt_i);
    load_use  = ex_load_i && ex_match;
    br_on_ex  = id_branch_i && ex_we_i && (ex_dst_i != '0) && ex_match;
    br_on_mem = id_branch_i && mem_load_i && (mem_dst_i != '0) && mem_match;
    stall_o   = load_use || br_on_ex || br_on_mem;
    flush_o   = id_branch_i && id_taken_i && !stall_o;
  end

  always_comb begin
    if (ex_load_i && (ex_dst_i == id_rs_i))
      a_r3_load_use_stall: assert (stall_o);
    if (flush_o)
      a_r7_flush_not_stalled: assert (!stall_o && id_branch_i);
    if (!id_branch_i)
      a_r7_no_flush_without_branch: assert (!flush_o);
  end
endmodule

// File: rtl/fwdctl_top.sv
module fwdctl_top
  import fwdctl_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_branch_i,
  input  logic             id_taken_i,
  input  logic [REG_W-1:0] ex_rs_i,
  input  logic [REG_W-1:0] ex_rt_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             ex_we_i,
  input  logic             ex_load_i,
  input  logic [REG_W-1:0] mem_dst_i,
  input  logic             mem_we_i,
  input  logic             mem_load_i,
  input  logic [REG_W-1:0] wb_dst_i,
  input  logic             wb_we_i,
  output logic [1:0]       ex_a_sel_o,
  output logic [1:0]       ex_b_sel_o,
  output logic [1:0]       id_a_sel_o,
  output logic [1:0]       id_b_sel_o,
  output logic             hold_pc_o,
  output logic             hold_ifid_o,
  output logic             bubble_idex_o,
  output logic             flush_ifid_o
);
  localparam int unsigned N_OPS = 4;  // 0,1 execute; 2,3 decode

  logic [REG_W-1:0] op_src [N_OPS];
  logic [1:0]       op_sel [N_OPS];
  logic             stall;

  assign op_src[0] = ex_rs_i;
  assign op_src[1] = ex_rt_i;
  assign op_src[2] = id_rs_i;
  assign op_src[3] = id_rt_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fwdctl_pick #(
      .REG_W     (REG_W),
      .LOAD_GUARD(g >= 2)
    ) u_pick (
      .src_i     (op_src[g]),
      .mem_we_i  (mem_we_i),
      .mem_load_i(mem_load_i),
      .mem_dst_i (mem_dst_i),
      .wb_we_i   (wb_we_i),
      .wb_dst_i  (wb_dst_i),
      .sel_o     (op_sel[g])
    );
  end

  fwdctl_hazard #(.REG_W(REG_W)) u_hazard (
    .id_rs_i    (id_rs_i),
    .id_rt_i    (id_rt_i),
    .id_branch_i(id_branch_i),
    .id_taken_i (id_taken_i),
    .ex_dst_i   (ex_dst_i),
    .ex_we_i    (ex_we_i),
    .ex_load_i  (ex_load_i),
    .mem_dst_i  (mem_dst_i),
    .mem_load_i (mem_load_i),
    .stall_o    (stall),
    .flush_o    (flush_ifid_o)
  );

  assign ex_a_sel_o    = op_sel[0];
  assign ex_b_sel_o    = op_sel[1];
  assign id_a_sel_o    = op_sel[2];
  assign id_b_sel_o    = op_sel[3];
  assign hold_pc_o     = stall;
  assign hold_ifid_o   = stall;
  assign bubble_idex_o = stall;

  always_comb begin
    if (id_branch_i && mem_load_i && mem_dst_i != '0 && mem_dst_i == id_rs_i)
      a_r5_branch_waits_load: assert (hold_pc_o && id_a_sel_o != SEL_MEM);
    if (id_branch_i && ex_we_i && ex_dst_i != '0 && ex_dst_i == id_rt_i)
      a_r4_branch_waits_alu: assert (hold_ifid_o && bubble_idex_o);
    if (ex_rs_i == '0)
      a_r8_zero_not_bypassed: assert (ex_a_sel_o == SEL_RF);
  end
endmodule

// File: tb/fwdctl_top_bench.sv
module fwdctl_top_bench;
  localparam int REG_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [REG_W-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic id_branch, id_taken, ex_we, ex_load, mem_we, mem_load, wb_we;
  logic [1:0] ex_a_sel, ex_b_sel, id_a_sel, id_b_sel;
  logic hold_pc, hold_ifid, bubble_idex, flush_ifid;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  fwdctl_top #(.REG_W(REG_W)) u_fwdctl_top (
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_branch_i(id_branch), .id_taken_i(id_taken),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_dst_i(ex_dst), .ex_we_i(ex_we),
    .ex_load_i(ex_load), .mem_dst_i(mem_dst), .mem_we_i(mem_we), .mem_load_i(mem_load),
    .wb_dst_i(wb_dst), .wb_we_i(wb_we),
    .ex_a_sel_o(ex_a_sel), .ex_b_sel_o(ex_b_sel), .id_a_sel_o(id_a_sel),
    .id_b_sel_o(id_b_sel), .hold_pc_o(hold_pc), .hold_ifid_o(hold_ifid),
    .bubble_idex_o(bubble_idex), .flush_ifid_o(flush_ifid)
  );

  // reference: where does a consumer of register r get its value
  function automatic int ref_src(int r, bit decode_side);
    if (r != 0 && mem_we && int'(mem_dst) == r && !(decode_side && mem_load)) return 2;
    if (r != 0 && wb_we && int'(wb_dst) == r) return 1;
    return 0;
  endfunction

  function automatic int ref_wait();
    int w = 0;
    if (ex_load && (ex_dst == id_rs || ex_dst == id_rt)) w = 1;
    if (id_branch) begin
      if (ex_dst != 0 && ex_we && (ex_dst == id_rs || ex_dst == id_rt))
        w = ex_load ? 2 : 1;
      else if (mem_dst != 0 && mem_load && (mem_dst == id_rs || mem_dst == id_rt))
        w = 1;
    end
    return w;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    int w;
    w = ref_wait();
    chk({tag, " R1"}, "ex_a_sel", int'(ex_a_sel), ref_src(int'(ex_rs), 1'b0));
    chk({tag, " R2"}, "ex_b_sel", int'(ex_b_sel), ref_src(int'(ex_rt), 1'b0));
    chk({tag, " R6"}, "id_a_sel", int'(id_a_sel), ref_src(int'(id_rs), 1'b1));
    chk({tag, " R6"}, "id_b_sel", int'(id_b_sel), ref_src(int'(id_rt), 1'b1));
    chk({tag, " R3"}, "hold_pc", int'(hold_pc), int'(w > 0));
    chk({tag, " R4"}, "hold_ifid", int'(hold_ifid), int'(w > 0));
    chk({tag, " R5"}, "bubble_idex", int'(bubble_idex), int'(w > 0));
    chk({tag, " R7"}, "flush_ifid", int'(flush_ifid), int'(id_branch && id_taken && w == 0));
  endtask

  task automatic clear_all();
    {id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst} = '0;
    {id_branch, id_taken, ex_we, ex_load, mem_we, mem_load, wb_we} = '0;
  endtask

  // drive at negedge, sample half a period later
  task automatic step(string tag);
    #10;
    compare_all(tag);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8 reset/idle state
    #10;
    chk("R8", "idle sel", int'({ex_a_sel, ex_b_sel, id_a_sel, id_b_sel}), 0);
    chk("R8", "idle stall", int'({hold_pc, hold_ifid, bubble_idex, flush_ifid}), 0);
    @(negedge clk);

    // R8 register 0 never bypassed
    ex_rs = 0; ex_rt = 0; mem_we = 1; mem_dst = 0; wb_we = 1; wb_dst = 0;
    #10;
    chk("R8", "zero ex_a", int'(ex_a_sel), 0);
    chk("R8", "zero ex_b", int'(ex_b_sel), 0);
    @(negedge clk);

    // R1/R2 priority: both stages match rs -> MEM; rt matches only WB
    clear_all();
    ex_rs = 2; ex_rt = 5; mem_we = 1; mem_dst = 2; wb_we = 1; wb_dst = 2;
    #10;
    chk("R1", "mem over wb", int'(ex_a_sel), 2);
    chk("R2", "rt no match", int'(ex_b_sel), 0);
    @(negedge clk);
    wb_dst = 5;
    #10;
    chk("R2", "wb to b", int'(ex_b_sel), 1);
    @(negedge clk);

    // R3 load-use: load to r2 in EX, consumer reads r2 in ID
    clear_all();
    ex_load = 1; ex_we = 1; ex_dst = 2; id_rs = 4; id_rt = 2;
    #10;
    chk("R3", "load-use hold", int'({hold_pc, hold_ifid, bubble_idex}), 7);
    @(negedge clk);

    // R4 branch on ALU result in EX: one wait, then MEM forward
    clear_all();
    id_branch = 1; id_taken = 1; id_rs = 2; ex_we = 1; ex_dst = 2;
    #10;
    chk("R4", "branch alu wait", int'(hold_pc), 1);
    chk("R7", "no flush while waiting", int'(flush_ifid), 0);
    @(negedge clk);
    ex_we = 0; ex_dst = 0; mem_we = 1; mem_dst = 2;
    #10;
    chk("R4", "branch alu released", int'(hold_pc), 0);
    chk("R6", "branch from mem", int'(id_a_sel), 2);
    chk("R7", "taken flush", int'(flush_ifid), 1);
    @(negedge clk);

    // R5 branch on load directly ahead: two waits, then WB forward
    clear_all();
    id_branch = 1; id_rt = 3; ex_load = 1; ex_we = 1; ex_dst = 3;
    step("R5 load in ex");
    ex_load = 0; ex_we = 0; ex_dst = 0; mem_load = 1; mem_we = 1; mem_dst = 3;
    #10;
    chk("R5", "second wait", int'(bubble_idex), 1);
    chk("R6", "no mem fwd of load", int'(id_b_sel), 0);
    @(negedge clk);
    mem_load = 0; mem_we = 0; mem_dst = 0; wb_we = 1; wb_dst = 3;
    #10;
    chk("R5", "released", int'(bubble_idex), 0);
    chk("R6", "from wb", int'(id_b_sel), 1);
    chk("R7", "not taken no flush", int'(flush_ifid), 0);
    @(negedge clk);

    // randomised sweep against reference
    for (int i = 0; i < 4000; i++) begin
      id_rs = REG_W'($urandom_range(0, 3)); id_rt = REG_W'($urandom_range(0, 3));
      ex_rs = REG_W'($urandom_range(0, 3)); ex_rt = REG_W'($urandom_range(0, 3));
      ex_dst = REG_W'($urandom_range(0, 3)); mem_dst = REG_W'($urandom_range(0, 3));
      wb_dst = REG_W'($urandom_range(0, 3));
      {id_branch, id_taken, ex_we, ex_load, mem_we, mem_load, wb_we} = 7'($urandom);
      step("rand");
    end
    summary();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        summary();
      end
    end
  end
endmodule